// File: doc/BRIEF.md
# Digital Phase Lock Detector

This block decides whether an integer-N PLL has settled. It takes the divided reference clock and the divided feedback clock and resynchronises both to a fast sample clock. It detects the rising edge of each. For every phase-detector cycle it counts the sample ticks between the edge that arrives first and the edge that arrives second, in either order. The result drives a single active-high lock flag.

Lock is acquired slowly and released reluctantly. The flag rises only after a run of consecutive cycles whose error falls inside an acquisition window. The window is either tight or loose, chosen by one select input. Once high, the flag falls only when a cycle shows an error beyond a wider loss threshold. If the second edge never arrives, the cycle counts as a loss. Power-down clears the whole detector.

Top module: `phase_lock_detect`

## Requirements
- R1: After reset the output `locked` is 0. The output is active high: 1 means locked.
- R2: With `fine_sel` = 0 and `locked` low, `locked` goes high after RUN_LEN (5) consecutive cycles whose error is strictly below COARSE_TICKS (10). It stays low after only four such cycles. An error of exactly 10 does not count as in-window.
- R3: With `fine_sel` = 1, the acquisition window is strictly below FINE_TICKS (3). Five cycles of error 2 set lock. Cycles of error 3 never set lock.
- R4: While locked, a cycle with an error up to and including LOSS_TICKS (25) leaves `locked` high.
- R5: While locked, a single cycle with an error greater than LOSS_TICKS drops `locked` to 0.
- R6: While `pwr_dn` is 1, `locked` is 0. The consecutive-good count restarts from zero after power-down.
- R7: If the second edge has not arrived LOSS_TICKS ticks after the first, the cycle closes as a loss. A reference pulse with no feedback pulse therefore drops lock.
- R8: While unlocked, any cycle outside the acquisition window clears the consecutive-good count. Five further in-window cycles are then needed.
- R9: The error is the unsigned distance between the two edges: feedback leading and feedback lagging by the same amount behave alike, and coincident edges give an error of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_dn | input | 1 | Power-down, clears the detector while 1 |
| fine_sel | input | 1 | 1 selects the tight acquisition window |
| ref_div | input | 1 | Divided reference clock (asynchronous) |
| fb_div | input | 1 | Divided feedback clock (asynchronous) |
| locked | output | 1 | Lock flag, active high |

## Verification
Edge offsets are tried with the feedback leading, lagging and coincident with the reference. Equal positive and negative offsets must give the same verdict, which separates a signed measurement from an absolute one. Offsets placed exactly on each window edge (2/3, 9/10, 25/26 ticks) expose off-by-one and strict-versus-inclusive comparisons. Runs of four good cycles broken by one bad cycle separate a counter that is cleared from one that merely pauses. A reference pulse with no feedback pulse shows whether a missing edge is closed as a loss or left pending. Randomised offsets with switching window selection are compared against a cycle-by-cycle model of the lock rules.

// File: rtl/phase_lock_detect.sv
module phase_lock_detect #(
  parameter int FINE_TICKS   = 3,
  parameter int COARSE_TICKS = 10,
  parameter int LOSS_TICKS   = 25,
  parameter int RUN_LEN      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic fine_sel,
  input  logic ref_div,
  input  logic fb_div,
  output logic locked
);
  localparam int CW = $clog2(LOSS_TICKS + 1);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FINE_C   = CW'(FINE_TICKS);
  localparam logic [CW-1:0] COARSE_C = CW'(COARSE_TICKS);
  localparam logic [CW-1:0] LOSS_C   = CW'(LOSS_TICKS);
  localparam logic [RW-1:0] LAST_C   = RW'(RUN_LEN - 1);

  logic [2:0] ref_q, fb_q;
  logic pend, pend_ref;
  logic [CW-1:0] tcnt;
  logic [RW-1:0] run;

  // two synchronizer flops plus one history flop per input
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_q <= '0;
      fb_q  <= '0;
    end else begin
      ref_q <= {ref_q[1:0], ref_div};
      fb_q  <= {fb_q[1:0], fb_div};
    end

  logic ref_e, fb_e, other_e, tmo, ev, good_ev;
  logic [CW-1:0] err, win;
  assign ref_e   = ref_q[1] & ~ref_q[2];
  assign fb_e    = fb_q[1] & ~fb_q[2];
  assign other_e = pend_ref ? fb_e : ref_e;
  assign tmo     = pend && !other_e && (tcnt == LOSS_C);
  assign ev      = (!pend && ref_e && fb_e) || (pend && other_e) || tmo;
  assign err     = pend ? tcnt : '0;
  assign win     = fine_sel ? FINE_C : COARSE_C;
  assign good_ev = ev && !tmo && (err < win);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_ref <= 1'b0;
      tcnt     <= '0;
    end else if (pwr_dn) begin
      pend     <= 1'b0;
      pend_ref <= 1'b0;
      tcnt     <= '0;
    end else if (!pend) begin
      if (ref_e ^ fb_e) begin
        pend     <= 1'b1;
        pend_ref <= ref_e;
        tcnt     <= CW'(1);
      end
    end else if (other_e || tmo) begin
      pend <= 1'b0;
      tcnt <= '0;
    end else begin
      tcnt <= tcnt + CW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      locked <= 1'b0;
      run    <= '0;
    end else if (pwr_dn) begin
      locked <= 1'b0;
      run    <= '0;
    end else if (ev) begin
      if (tmo) begin
        locked <= 1'b0;
        run    <= '0;
      end else if (!locked) begin
        if (!good_ev)            run <= '0;
        else if (run == LAST_C) begin
          locked <= 1'b1;
          run    <= '0;
        end else                 run <= run + RW'(1);
      end
    end

  AST_PD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !locked); // R6
  AST_DROP_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(tmo || pwr_dn)); // R5
  AST_RISE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(good_ev && run == LAST_C)); // R2
  AST_PEND_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> tcnt <= LOSS_C); // R7
  AST_HOLD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && ev && !tmo && !pwr_dn) |=> locked); // R4
  AST_BAD_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && ev && !good_ev && !pwr_dn) |=> run == '0); // R8
endmodule

// File: tb/phase_lock_detect_test.sv
`timescale 1ns/1ps
module phase_lock_detect_test;
  localparam int FINE = 3, COARSE = 10, LOSS = 25, RUNL = 5, SLOT = 60;

  logic clk = 0, rst_n = 0, pwr_dn = 0, fine_sel = 0, ref_div = 0, fb_div = 0;
  logic locked;
  int checks = 0, errors = 0;
  bit m_lock = 0, done = 0;
  int m_run = 0;

  phase_lock_detect uut (.clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .fine_sel(fine_sel),
                         .ref_div(ref_div), .fb_div(fb_div), .locked(locked));

  always #2 clk = ~clk;

  function automatic int absv(int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic model_step(int err, bit big);
    int win = fine_sel ? FINE : COARSE;
    if (big || err > LOSS) begin m_lock = 0; m_run = 0; end
    else if (!m_lock) begin
      if (err < win) begin
        m_run++;
        if (m_run == RUNL) begin m_lock = 1; m_run = 0; end
      end else m_run = 0;
    end
  endtask

  task automatic check(string tag, bit exp);
    checks++;
    if (locked !== exp) begin
      errors++;
      $display("FAIL %s: locked=%0b expected=%0b", tag, locked, exp);
    end
  endtask

  // one phase-detector cycle; fb offset d relative to ref (negative = fb leads)
  task automatic slot(int d, bit fb_on);
    for (int c = 0; c < SLOT; c++) begin
      @(negedge clk);
      ref_div = (c >= 20 && c < 28);
      fb_div  = fb_on && (c >= 20 + d && c < 28 + d);
    end
    @(negedge clk);
    ref_div = 0; fb_div = 0;
    model_step(absv(d), !fb_on || absv(d) > LOSS);
  endtask

  task automatic run_slot(string tag, int d);
    slot(d, 1'b1);
    check(tag, m_lock);
  endtask

  task automatic gap_slot(string tag);
    slot(0, 1'b0);
    check(tag, m_lock);
  endtask

  task automatic power_down(string tag);
    @(negedge clk); pwr_dn = 1;
    repeat (3) @(negedge clk);
    check(tag, 1'b0);
    pwr_dn = 0; m_lock = 0; m_run = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: locked=%0b expected=finish", locked);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 idle", 1'b0);

    // R2 / R9: coarse window, mixed lead/lag/coincident
    fine_sel = 0;
    run_slot("R9 zero", 0);
    run_slot("R9 lag", 9);
    run_slot("R9 lead", -9);
    run_slot("R2 four", 5);
    check("R2 not yet", 1'b0);
    run_slot("R2 fifth", -3);
    check("R2 locked", 1'b1);
    // R4 hold at loss boundary
    run_slot("R4 at 25", 25);
    run_slot("R4 at -20", -20);
    check("R4 held", 1'b1);
    // R5 drop on 26
    run_slot("R5 at 26", 26);
    check("R5 dropped", 1'b0);
    // R8 + R2 boundary: 4 good then exactly 10
    for (int i = 0; i < 4; i++) run_slot("R8 good", 1);
    run_slot("R2 at 10", -10);
    for (int i = 0; i < 4; i++) run_slot("R8 after clear", 2);
    check("R8 still unlocked", 1'b0);
    run_slot("R8 fifth", 0);
    check("R8 relock", 1'b1);
    // R7 missing feedback edge
    gap_slot("R7 no fb");
    check("R7 dropped", 1'b0);
    // R6 power-down clears lock and run
    for (int i = 0; i < 5; i++) run_slot("R6 acquire", 4);
    power_down("R6 in pd");
    for (int i = 0; i < 4; i++) run_slot("R6 count reset", 4);
    check("R6 not locked", 1'b0);
    // R3 fine window
    power_down("R3 pd");
    fine_sel = 1;
    for (int i = 0; i < 5; i++) run_slot("R3 err2", 2);
    check("R3 locked", 1'b1);
    power_down("R3 pd2");
    for (int i = 0; i < 6; i++) run_slot("R3 err3", 3);
    check("R3 err3 never", 1'b0);
    for (int i = 0; i < 5; i++) run_slot("R9 fine lead", -2);
    check("R9 fine lead lock", 1'b1);

    // random phase offsets and window switching
    for (int i = 0; i < 220; i++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 3) begin
        slot(30, 1'b1); gap_slot("R7 random late");
      end else if (r < 5) begin
        power_down("R6 random");
      end else begin
        if (r < 12) fine_sel = ~fine_sel;
        run_slot("R2 random", int'($urandom_range(0, 28)) - 14);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule